// File: doc/BRIEF.md
# Shader Vector Compare-Select Unit

This block executes the comparison and selection instructions of a programmable shader on four-component single-precision vectors. One instruction is accepted per clock. It carries an opcode and up to three source vectors. Each of the four lanes, x, y, z and w, works on its own component. A lane either passes one of its source components through or writes one of the constants 1.0, 0.0 and -1.0.

Every comparison works directly on the IEEE-754 bit patterns by sign-magnitude ordering, so the block has no floating-point subtractor. Positive and negative zero are treated as equal. The result and its valid strobe are registered and appear one clock after the instruction. NaN handling and denormal flushing are outside the function: such patterns are simply ordered by their bits.

Top module: `vcs_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is 0 and `result` is all zeros after that edge.
- R2: `out_valid` equals `in_valid` of the previous clock edge, and `result` reflects the instruction accepted at that edge.
- R3: Opcode 0 (select on sign): each lane outputs its src1 component when its src0 component is >= 0, and its src2 component otherwise.
- R4: Opcode 1 (maximum): each lane outputs src0 when src0 > src1, and src1 otherwise.
- R5: Opcode 2 (minimum): each lane outputs src0 when src0 < src1, and src1 otherwise.
- R6: Opcode 3 (set if greater or equal): each lane outputs 0x3F800000 when src0 >= src1, and 0x00000000 otherwise.
- R7: Opcode 4 (set if less than): each lane outputs 0x3F800000 when src0 < src1, and 0x00000000 otherwise.
- R8: Opcode 5 (sign): each lane outputs 0x3F800000 when src0 > 0, 0x00000000 when src0 == 0, and 0xBF800000 when src0 < 0.
- R9: Ordering is sign-magnitude on the bit patterns. Bit 31 is the sign. For two positives the larger bits[30:0] is greater. For two negatives the larger bits[30:0] is smaller. Any negative is below any positive. 0x00000000 and 0x80000000 compare equal.
- R10: Opcodes 6 and 7 write 0x00000000 to every lane.
- R11: A clock edge with `in_valid` low leaves `result` unchanged.
- R12: Lane k (x=0, y=1, z=2, w=3) occupies bits [32k+31:32k] of every vector, and each lane's output depends only on that lane's source components.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 3 | Operation select |
| src0 | input | 128 | First source vector |
| src1 | input | 128 | Second source vector |
| src2 | input | 128 | Third source vector (select only) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 128 | Registered destination vector |

## Verification
Several properties are checked on every cycle:
- the one-cycle valid latency;
- the holding of the result when no instruction arrives;
- that select, maximum and minimum lanes always carry one of their own sources;
- that the set and sign opcodes emit only the allowed constants.

Which source or constant is the correct one depends on the ordering, and only the bench's scenarios show it. These scenarios cover:
- signed zeros and equal operands;
- mixed-sign and two-negative comparisons;
- the reserved opcodes;
- lanes fed with unrelated data.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned COMP_W = 32;
    localparam int unsigned VEC_W  = LANES * COMP_W;

    localparam logic [COMP_W-1:0] FP_ONE     = 32'h3F80_0000;
    localparam logic [COMP_W-1:0] FP_ZERO    = 32'h0000_0000;
    localparam logic [COMP_W-1:0] FP_NEG_ONE = 32'hBF80_0000;

    typedef enum logic [2:0] {
        OP_SEL  = 3'd0,
        OP_MAX  = 3'd1,
        OP_MIN  = 3'd2,
        OP_SGE  = 3'd3,
        OP_SLT  = 3'd4,
        OP_SGN  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } vcs_op_e;

    typedef struct packed {
        logic lt;
        logic eq;
    } cmp_flags_t;

    // Maps a float bit pattern to a signed integer with the same order;
    // both zeros map to 0.
    function automatic logic signed [COMP_W:0] order_key(logic [COMP_W-1:0] v);
        logic signed [COMP_W:0] m;
        m = signed'({2'b00, v[COMP_W-2:0]});
        return v[COMP_W-1] ? -m : m;
    endfunction

endpackage

// File: rtl/vcs_lane_cmp.sv
module vcs_lane_cmp
    import vcs_pkg::*;
(
    input  logic [COMP_W-1:0] a,
    input  logic [COMP_W-1:0] b,
    output cmp_flags_t        flags
);
    logic signed [COMP_W:0] ka;
    logic signed [COMP_W:0] kb;

    always_comb begin
        ka       = order_key(a);
        kb       = order_key(b);
        flags.lt = (ka < kb);
        flags.eq = (ka == kb);
    end
endmodule

// File: rtl/vcs_lane.sv
module vcs_lane
    import vcs_pkg::*;
(
    input  vcs_op_e           op,
    input  logic [COMP_W-1:0] s0,
    input  logic [COMP_W-1:0] s1,
    input  logic [COMP_W-1:0] s2,
    output logic [COMP_W-1:0] dst
);
    cmp_flags_t f01;
    cmp_flags_t f0z;

    vcs_lane_cmp u_cmp_pair (.a(s0), .b(s1),      .flags(f01));
    vcs_lane_cmp u_cmp_zero (.a(s0), .b(FP_ZERO), .flags(f0z));

    always_comb begin
        unique case (op)
            OP_SEL:  dst = f0z.lt ? s2 : s1;
            OP_MAX:  dst = (!f01.lt && !f01.eq) ? s0 : s1;
            OP_MIN:  dst = f01.lt ? s0 : s1;
            OP_SGE:  dst = f01.lt ? FP_ZERO : FP_ONE;
            OP_SLT:  dst = f01.lt ? FP_ONE : FP_ZERO;
            OP_SGN:  dst = f0z.lt ? FP_NEG_ONE : (f0z.eq ? FP_ZERO : FP_ONE);
            default: dst = FP_ZERO;
        endcase
    end
endmodule

// File: rtl/vcs_unit.sv
module vcs_unit
    import vcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       opcode,
    input  logic [VEC_W-1:0] src0,
    input  logic [VEC_W-1:0] src1,
    input  logic [VEC_W-1:0] src2,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    vcs_op_e          op;
    logic [VEC_W-1:0] lane_out;

    assign op = vcs_op_e'(opcode);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        vcs_lane u_lane (
            .op (op),
            .s0 (src0[k*COMP_W +: COMP_W]),
            .s1 (src1[k*COMP_W +: COMP_W]),
            .s2 (src2[k*COMP_W +: COMP_W]),
            .dst(lane_out[k*COMP_W +: COMP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= lane_out;
        end
    end

    // R2: valid follows input one cycle later
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R11: idle cycles keep the result
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R3: select lane carries src1 or src2
        a_r3_sel_src: assert property (@(posedge clk) disable iff (rst)
            (in_valid && opcode == 3'd0) |=>
            (result[k*COMP_W +: COMP_W] == $past(src1[k*COMP_W +: COMP_W]) ||
             result[k*COMP_W +: COMP_W] == $past(src2[k*COMP_W +: COMP_W])));
        // R4/R5: max and min lanes carry one of the two compared sources
        a_r4_r5_pick_src: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (opcode == 3'd1 || opcode == 3'd2)) |=>
            (result[k*COMP_W +: COMP_W] == $past(src0[k*COMP_W +: COMP_W]) ||
             result[k*COMP_W +: COMP_W] == $past(src1[k*COMP_W +: COMP_W])));
        // R6/R7: set opcodes give only 1.0 or 0.0
        a_r6_r7_set_const: assert property (@(posedge clk) disable iff (rst)
            (in_valid && (opcode == 3'd3 || opcode == 3'd4)) |=>
            (result[k*COMP_W +: COMP_W] == FP_ONE ||
             result[k*COMP_W +: COMP_W] == FP_ZERO));
        // R8: sign opcode gives only the three constants
        a_r8_sgn_const: assert property (@(posedge clk) disable iff (rst)
            (in_valid && opcode == 3'd5) |=>
            (result[k*COMP_W +: COMP_W] == FP_ONE ||
             result[k*COMP_W +: COMP_W] == FP_ZERO ||
             result[k*COMP_W +: COMP_W] == FP_NEG_ONE));
        // R10: reserved opcodes clear the lane
        a_r10_rsv_zero: assert property (@(posedge clk) disable iff (rst)
            (in_valid && opcode[2:1] == 2'b11) |=>
            (result[k*COMP_W +: COMP_W] == FP_ZERO));
    end
endmodule

// File: tb/vcs_unit_tb.sv
`timescale 1ns/1ps
module vcs_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   opcode;
    logic [127:0] src0, src1, src2;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_res;

    always #2 clk = ~clk;

    vcs_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .src0(src0), .src1(src1), .src2(src2),
        .out_valid(out_valid), .result(result)
    );

    // true when a is strictly below b in float order, zeros equal
    function automatic bit ref_below(logic [31:0] a, logic [31:0] b);
        bit za, zb;
        za = (a[30:0] == 0);
        zb = (b[30:0] == 0);
        if (za && zb) return 0;
        if (za) return ~b[31] ? 1 : 0;
        if (zb) return a[31];
        if (a[31] != b[31]) return a[31];
        if (!a[31]) return a[30:0] < b[30:0];
        return a[30:0] > b[30:0];
    endfunction

    function automatic logic [31:0] ref_lane(int op, logic [31:0] a,
                                             logic [31:0] b, logic [31:0] c);
        case (op)
            0: return ref_below(a, 32'h0) ? c : b;
            1: return ref_below(b, a) ? a : b;
            2: return ref_below(a, b) ? a : b;
            3: return ref_below(a, b) ? 32'h0 : 32'h3F80_0000;
            4: return ref_below(a, b) ? 32'h3F80_0000 : 32'h0;
            5: begin
                if (ref_below(a, 32'h0)) return 32'hBF80_0000;
                if (ref_below(32'h0, a)) return 32'h3F80_0000;
                return 32'h0;
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(string req, bit v, int op,
                         logic [127:0] a, logic [127:0] b, logic [127:0] c);
        @(negedge clk);
        in_valid = v; opcode = 3'(op); src0 = a; src1 = b; src2 = c;
        if (v)
            for (int k = 0; k < 4; k++)
                exp_res[k*32 +: 32] = ref_lane(op, a[k*32 +: 32], b[k*32 +: 32], c[k*32 +: 32]);
        @(negedge clk);
        check({req, " valid"}, {127'b0, out_valid}, {127'b0, v});
        check(req, result, exp_res);
        in_valid = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; opcode = '0; src0 = '0; src1 = '0; src2 = '0;
        exp_res = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", {127'b0, out_valid}, 128'b0);
        check("R1 result", result, 128'b0);
        rst = 1'b0;

        // R3: +0, -0, positive, negative in lanes x..w
        issue("R3 sel zeros", 1, 0,
              {32'hC000_0000, 32'h4000_0000, 32'h8000_0000, 32'h0000_0000},
              {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444},
              {32'h5555_5555, 32'h6666_6666, 32'h7777_7777, 32'h8888_8888});
        // R4/R9: mixed signs, two negatives, equal, +0 vs -0
        issue("R4 max", 1, 1,
              {32'hBF80_0000, 32'hC000_0000, 32'h4040_0000, 32'h0000_0000},
              {32'h3F80_0000, 32'hBF80_0000, 32'h4040_0000, 32'h8000_0000}, '0);
        issue("R5 min", 1, 2,
              {32'hBF80_0000, 32'hC000_0000, 32'h4040_0000, 32'h0000_0000},
              {32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000, 32'h8000_0000}, '0);
        issue("R6 sge equal", 1, 3,
              {32'h8000_0000, 32'hC000_0000, 32'h4040_0000, 32'h3F80_0000},
              {32'h0000_0000, 32'hBF80_0000, 32'h4080_0000, 32'h3F80_0000}, '0);
        issue("R7 slt", 1, 4,
              {32'h8000_0000, 32'hC000_0000, 32'h4040_0000, 32'h3F80_0000},
              {32'h0000_0000, 32'hBF80_0000, 32'h4080_0000, 32'h3F80_0000}, '0);
        issue("R8 sgn", 1, 5,
              {32'h8000_0000, 32'h0000_0000, 32'hC120_0000, 32'h0000_0001},
              '0, '0);
        issue("R9 neg order", 1, 4,
              {32'hC120_0000, 32'hBF80_0000, 32'h0000_0001, 32'h8000_0001},
              {32'hC000_0000, 32'hC000_0000, 32'h8000_0001, 32'h0000_0000}, '0);
        issue("R10 rsv6", 1, 6, {4{32'h3F80_0000}}, {4{32'h4000_0000}}, {4{32'h1}});
        issue("R4 after rsv", 1, 1, {4{32'h4000_0000}}, {4{32'h3F80_0000}}, '0);
        issue("R10 rsv7", 1, 7, {4{32'h3F80_0000}}, {4{32'h4000_0000}}, {4{32'h1}});
        issue("R8 reload", 1, 5, {32'h3F80_0000, 32'hBF80_0000, 32'h0, 32'h4000_0000}, '0, '0);
        // R11: idle cycle with changed inputs keeps result
        issue("R11 hold", 0, 1, {4{32'h7F00_0000}}, {4{32'h1}}, '0);
        issue("R11 hold2", 0, 0, {4{32'hFFFF_FFFF}}, {4{32'h1234_5678}}, '0);
        // R12/R2: random lanes with mixed opcodes
        for (int i = 0; i < 300; i++) begin
            logic [127:0] a, b, c;
            for (int k = 0; k < 4; k++) begin
                a[k*32 +: 32] = $urandom;
                b[k*32 +: 32] = ($urandom_range(0, 3) == 0) ? a[k*32 +: 32] ^ 32'h8000_0000 : $urandom;
                c[k*32 +: 32] = $urandom;
            end
            if (i % 7 == 0) a[31:0] = 32'h8000_0000;
            issue("R12 random", ($urandom_range(0, 4) != 0), $urandom_range(0, 7), a, b, c);
        end
        rst = 1'b1;
        @(negedge clk);
        check("R1 reapply", {out_valid, result[126:0]}, 128'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule